// File: doc/BRIEF.md
# Serial Bus PHY Control Register Bank

This block is the host-visible control and event register set of a serial bus physical layer. A host accesses it through a plain synchronous read/write port with a 4-bit address and 8-bit data. The lower half of the address space holds three local registers:

- a control register with request and enable bits;
- a sticky event register that the host clears by writing ones;
- a select register that steers accesses to the upper half.

Accesses to addresses 8 to 15 go to an external paged register file. The block drives the current page and port selection toward that file and returns the file's read data.

Event inputs from the rest of the PHY latch into the sticky bits:

- an arbitration timeout during tree identification;
- a falling edge on the asynchronous cable power sense input;
- a state timeout;
- status changes on interrupt-enabled ports;
- port resume starts, when the watchdog bit is set.

When a loop event is pending with the watchdog set and the link layer is inactive, the block requests link wake-up. A hardware reset (asynchronous `rst_ni`) clears every field. A bus reset (`bus_rst_i`) clears only the short reset request.

Top module: `phy_ctl_regs`

## Requirements
- R1: While and after hardware reset, every readable field is 0, all control outputs are 0 and `link_wake_o` is low.
- R2: Address 0 bit 0 is the short reset request. A write sets it to the written value, and it is driven on `short_rst_req_o`. A `bus_rst_i` cycle clears it, and the bus reset takes priority over a write to it in the same cycle.
- R3: At address 0, bit 1 is the accelerated arbitration enable, bit 2 is the multispeed enable and bit 3 is the watchdog. All three are read/write, and bits 7:4 read 0. `bus_rst_i` leaves bits 3:1 unchanged.
- R4: Address 2 holds the page select in bits 2:0 and the port select in bits 7:4. Both are read/write, are driven on `page_o`/`port_o`, and are unaffected by `bus_rst_i`.
- R5: Address 1 bit 0 (loop) is set by an `arb_tmo_i` cycle. Writing 1 to that bit clears it, and writing 0 leaves it. Bits 7:4 of address 1 read 0.
- R6: Address 1 bit 1 (power fail) is set once for each high-to-low transition of `cps_i`. `cps_i` passes through two synchronizer flops and an edge stage, so the bit reads 1 after the third rising clock edge that samples the low level. It is cleared by writing 1.
- R7: Address 1 bit 2 (state timeout) is set by a `state_tmo_i` cycle and cleared by writing 1.
- R8: Address 1 bit 3 (port event) is set when any of the 4 status bits of a port changes from one cycle to the next, provided that port's `port_int_en_i` bit is 1. Changes on disabled ports are ignored. It is cleared by writing 1.
- R9: A `port_resume_i` bit sets the port event bit only while the watchdog bit is 1.
- R10: When an event and a write-one-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R11: `link_wake_o` is high exactly while the loop bit and the watchdog bit are both 1 and `link_active_i` is 0.
- R12: For addresses 8 to 15, `reg_rdata_o` equals `paged_rdata_i` and `paged_acc_o` follows `reg_en_i`. Writes to these addresses leave the local registers unchanged. Addresses 3 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when 1, read when 0 |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| paged_rdata_i | input | 8 | Read data from the external paged registers |
| paged_acc_o | output | 1 | Access to addresses 8 to 15 in progress |
| page_o | output | 3 | Selected register page |
| port_o | output | 4 | Selected port index |
| bus_rst_i | input | 1 | Bus reset occurred this cycle |
| arb_tmo_i | input | 1 | Arbitration timeout during tree identification |
| state_tmo_i | input | 1 | State timeout |
| cps_i | input | 1 | Asynchronous cable power sense |
| port_stat_i | input | 16 | Per-port status, 4 bits per port, port 0 in the low bits |
| port_int_en_i | input | 4 | Per-port interrupt enable |
| port_resume_i | input | 4 | Per-port resume start strobe |
| link_active_i | input | 1 | Link layer is active |
| link_wake_o | output | 1 | Link activation request |
| short_rst_req_o | output | 1 | Short bus reset request |
| accel_en_o | output | 1 | Accelerated arbitration enable |
| multi_en_o | output | 1 | Multispeed concatenation enable |

## Verification
Two pairs of operations can fall in the same cycle. The first pair is a hardware event and a host write-one-to-clear aimed at the same sticky bit. The second is a bus reset and a host write to the short reset request. The bench drives each pair on a single clock by raising the event strobe together with the clearing write, or `bus_rst_i` together with the control write. A behavioural model applies the stated priorities: the set survives the clear, and the bus reset overrides the write. Every field is compared against that model on each falling edge, so an inverted priority appears as a mismatch one cycle after the collision.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int STAT_W = 4;
  localparam int N_EVT  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd2;

  // sticky event bit positions at A_EVT
  localparam int EV_LOOP = 0;
  localparam int EV_PWR  = 1;
  localparam int EV_STMO = 2;
  localparam int EV_PORT = 3;

  // control bit positions at A_CTRL
  localparam int CB_SRR   = 0;
  localparam int CB_ACCEL = 1;
  localparam int CB_MULTI = 2;
  localparam int CB_WDOG  = 3;

  localparam int SEL_PORT_LSB = 4;
endpackage

// File: rtl/phy_cps_edge.sv
module phy_cps_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cps_i,
  output logic fall_o
);
  logic s1_q, s2_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      s1_q   <= cps_i;
      s2_q   <= s1_q;
      last_q <= s2_q;
    end
  end

  assign fall_o = last_q & ~s2_q;

  // one pulse per falling edge
  p_single_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/phy_port_evt.sv
module phy_port_evt import phy_ctl_pkg::*; #(
  parameter int N_PORT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PORT*STAT_W-1:0] stat_i,
  input  logic [N_PORT-1:0]        int_en_i,
  input  logic [N_PORT-1:0]        resume_i,
  input  logic                     wdog_i,
  output logic                     evt_o
);
  localparam int SW = STAT_W;

  logic [N_PORT*SW-1:0] prev_q;
  logic                 vld_q;
  logic [N_PORT-1:0]    hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= stat_i;
      vld_q  <= 1'b1;
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign hit[p] = int_en_i[p] & vld_q &
                    (|(stat_i[p*SW +: SW] ^ prev_q[p*SW +: SW]));
  end

  assign evt_o = (|hit) | (wdog_i & (|resume_i));

  p_resume_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdog_i && $stable(stat_i)) |-> !evt_o);
endmodule

// File: rtl/phy_sticky.sv
module phy_sticky #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign q_o = q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((q_o & ~$past(q_o)) == '0));
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs import phy_ctl_pkg::*; #(
  parameter int N_PORT = 4,
  parameter int PAGE_W = 3,
  parameter int PSEL_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_en_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  input  logic [DATA_W-1:0]        paged_rdata_i,
  output logic                     paged_acc_o,
  output logic [PAGE_W-1:0]        page_o,
  output logic [PSEL_W-1:0]        port_o,
  input  logic                     bus_rst_i,
  input  logic                     arb_tmo_i,
  input  logic                     state_tmo_i,
  input  logic                     cps_i,
  input  logic [N_PORT*STAT_W-1:0] port_stat_i,
  input  logic [N_PORT-1:0]        port_int_en_i,
  input  logic [N_PORT-1:0]        port_resume_i,
  input  logic                     link_active_i,
  output logic                     link_wake_o,
  output logic                     short_rst_req_o,
  output logic                     accel_en_o,
  output logic                     multi_en_o
);
  logic              wr, paged, wr_ctrl, wr_evt, wr_sel;
  logic              srr_q, accel_q, multi_q, wdog_q;
  logic [PAGE_W-1:0] page_q;
  logic [PSEL_W-1:0] port_q;
  logic              pwr_fall, port_evt;
  logic [N_EVT-1:0]  evt_set, evt_clr, evt_q;

  assign wr      = reg_en_i & reg_we_i;
  assign paged   = reg_addr_i[ADDR_W-1];
  assign wr_ctrl = wr & (reg_addr_i == A_CTRL);
  assign wr_evt  = wr & (reg_addr_i == A_EVT);
  assign wr_sel  = wr & (reg_addr_i == A_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr_q   <= 1'b0;
      accel_q <= 1'b0;
      multi_q <= 1'b0;
      wdog_q  <= 1'b0;
      page_q  <= '0;
      port_q  <= '0;
    end else begin
      if (bus_rst_i)    srr_q <= 1'b0;
      else if (wr_ctrl) srr_q <= reg_wdata_i[CB_SRR];
      if (wr_ctrl) begin
        accel_q <= reg_wdata_i[CB_ACCEL];
        multi_q <= reg_wdata_i[CB_MULTI];
        wdog_q  <= reg_wdata_i[CB_WDOG];
      end
      if (wr_sel) begin
        page_q <= reg_wdata_i[PAGE_W-1:0];
        port_q <= reg_wdata_i[SEL_PORT_LSB +: PSEL_W];
      end
    end
  end

  phy_cps_edge i_cps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cps_i  (cps_i),
    .fall_o (pwr_fall)
  );

  phy_port_evt #(.N_PORT(N_PORT)) i_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_i   (port_stat_i),
    .int_en_i (port_int_en_i),
    .resume_i (port_resume_i),
    .wdog_i   (wdog_q),
    .evt_o    (port_evt)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_LOOP] = arb_tmo_i;
    evt_set[EV_PWR]  = pwr_fall;
    evt_set[EV_STMO] = state_tmo_i;
    evt_set[EV_PORT] = port_evt;
  end
  assign evt_clr = wr_evt ? reg_wdata_i[N_EVT-1:0] : '0;

  phy_sticky #(.W(N_EVT)) i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .q_o    (evt_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (paged) begin
      reg_rdata_o = paged_rdata_i;
    end else begin
      unique case (reg_addr_i)
        A_CTRL: begin
          reg_rdata_o[CB_SRR]   = srr_q;
          reg_rdata_o[CB_ACCEL] = accel_q;
          reg_rdata_o[CB_MULTI] = multi_q;
          reg_rdata_o[CB_WDOG]  = wdog_q;
        end
        A_EVT: reg_rdata_o[N_EVT-1:0] = evt_q;
        A_SEL: begin
          reg_rdata_o[PAGE_W-1:0]              = page_q;
          reg_rdata_o[SEL_PORT_LSB +: PSEL_W]  = port_q;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign paged_acc_o     = reg_en_i & paged;
  assign page_o          = page_q;
  assign port_o          = port_q;
  assign short_rst_req_o = srr_q;
  assign accel_en_o      = accel_q;
  assign multi_en_o      = multi_q;
  assign link_wake_o     = evt_q[EV_LOOP] & wdog_q & ~link_active_i;

  p_bus_rst_srr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !short_rst_req_o);

  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> ($stable(accel_en_o) && $stable(multi_en_o)));

  p_sel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel |=> ($stable(page_o) && $stable(port_o)));

  p_wake_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_wake_o |-> !link_active_i);
endmodule

// File: tb/test_phy_ctl_regs.sv
module test_phy_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata, paged_rdata = 8'hA5;
  logic        paged_acc;
  logic [2:0]  page;
  logic [3:0]  port;
  logic        bus_rst = 0, arb_tmo = 0, state_tmo = 0, cps = 0;
  logic [15:0] port_stat = '0;
  logic [3:0]  port_int_en = '0, port_resume = '0;
  logic        link_active = 1'b1, link_wake, srr, accel, multi;

  int total = 0, bad = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  phy_ctl_regs i_phy_ctl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .reg_en_i(reg_en), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .paged_rdata_i(paged_rdata), .paged_acc_o(paged_acc), .page_o(page),
    .port_o(port), .bus_rst_i(bus_rst), .arb_tmo_i(arb_tmo),
    .state_tmo_i(state_tmo), .cps_i(cps), .port_stat_i(port_stat),
    .port_int_en_i(port_int_en), .port_resume_i(port_resume),
    .link_active_i(link_active), .link_wake_o(link_wake),
    .short_rst_req_o(srr), .accel_en_o(accel), .multi_en_o(multi));

  // behavioural reference
  bit m_srr, m_acc, m_mul, m_wdg, m_loop, m_pwr, m_stmo, m_pevt, m_primed;
  int m_page, m_port;
  bit m_cps[3];
  logic [15:0] m_prev;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_srr, m_acc, m_mul, m_wdg, m_loop, m_pwr, m_stmo, m_pevt, m_primed} = '0;
      m_page = 0; m_port = 0; m_prev = '0;
      foreach (m_cps[k]) m_cps[k] = 0;
    end else begin
      bit w, fall, pset, old_wdg;
      w = reg_en && reg_we;
      old_wdg = m_wdg;
      fall = m_cps[2] && !m_cps[1];
      m_cps[2] = m_cps[1]; m_cps[1] = m_cps[0]; m_cps[0] = cps;
      pset = 0;
      for (int p = 0; p < 4; p++)
        if (m_primed && port_int_en[p] && (port_stat[p*4 +: 4] != m_prev[p*4 +: 4]))
          pset = 1;
      if (old_wdg && (port_resume != 0)) pset = 1;
      m_prev = port_stat; m_primed = 1;
      if (w && reg_addr == 0) begin
        m_acc = reg_wdata[1]; m_mul = reg_wdata[2]; m_wdg = reg_wdata[3];
        m_srr = reg_wdata[0];
      end
      if (bus_rst) m_srr = 0;
      if (w && reg_addr == 2) begin
        m_page = reg_wdata[2:0]; m_port = reg_wdata[7:4];
      end
      if (w && reg_addr == 1) begin
        if (reg_wdata[0]) m_loop = 0;
        if (reg_wdata[1]) m_pwr  = 0;
        if (reg_wdata[2]) m_stmo = 0;
        if (reg_wdata[3]) m_pevt = 0;
      end
      if (arb_tmo)   m_loop = 1;
      if (fall)      m_pwr  = 1;
      if (state_tmo) m_stmo = 1;
      if (pset)      m_pevt = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) act=%0h exp=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ew;
    chk(srr == m_srr, "R2", srr, m_srr);
    chk(accel == m_acc, "R3", accel, m_acc);
    chk(multi == m_mul, "R3", multi, m_mul);
    chk(page == m_page[2:0], "R4", page, m_page);
    chk(port == m_port[3:0], "R4", port, m_port);
    ew = m_loop && m_wdg && !link_active;
    chk(link_wake == ew, "R11", link_wake, ew);
    chk(paged_acc == (reg_en && reg_addr[3]), "R12", paged_acc, reg_en && reg_addr[3]);
    if (reg_addr[3]) chk(reg_rdata == paged_rdata, "R12", reg_rdata, paged_rdata);
    else case (reg_addr)
      0: begin
        chk(reg_rdata[0] == m_srr, "R2", reg_rdata[0], m_srr);
        chk(reg_rdata[7:1] == {4'b0, m_wdg, m_mul, m_acc}, "R3", reg_rdata[7:1],
            {4'b0, m_wdg, m_mul, m_acc});
      end
      1: begin
        chk(reg_rdata[0] == m_loop, "R5", reg_rdata[0], m_loop);
        chk(reg_rdata[1] == m_pwr,  "R6", reg_rdata[1], m_pwr);
        chk(reg_rdata[2] == m_stmo, "R7", reg_rdata[2], m_stmo);
        chk(reg_rdata[3] == m_pevt, "R8", reg_rdata[3], m_pevt);
        chk(reg_rdata[7:4] == 0, "R5", reg_rdata[7:4], 0);
      end
      2: chk(reg_rdata == {m_port[3:0], 1'b0, m_page[2:0]}, "R4", reg_rdata,
             {m_port[3:0], 1'b0, m_page[2:0]});
      default: chk(reg_rdata == 0, "R12", reg_rdata, 0);
    endcase
  endtask

  task automatic next();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      reg_en = 1; reg_we = 0; reg_addr = 4'(i % 3);
      next();
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    next();
    reg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    phase = "R1";
    for (int a = 0; a < 3; a++) begin reg_addr = 4'(a); next(); end
    rst_ni = 1'b1;
    idle(3);

    phase = "R3";
    wr(0, 8'h0E); idle(3);
    bus_rst = 1; next(); bus_rst = 0; idle(3);

    phase = "R2";
    wr(0, 8'h0F); idle(2);
    bus_rst = 1; next(); bus_rst = 0; idle(2);
    wr(0, 8'h01); idle(1);
    bus_rst = 1; reg_en = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'h0F;
    next(); bus_rst = 0; reg_we = 0; idle(2);

    phase = "R4";
    wr(2, 8'h53); idle(3);
    bus_rst = 1; next(); bus_rst = 0; idle(3);

    phase = "R12";
    wr(9, 8'hFF); idle(3);
    reg_addr = 4'hC; next();
    paged_rdata = 8'h3C; next();
    reg_addr = 4'h5; next();
    reg_en = 0; reg_addr = 4'hA; next();

    phase = "R5";
    arb_tmo = 1; next(); arb_tmo = 0; idle(3);
    wr(1, 8'h00); idle(2);
    wr(1, 8'h01); idle(2);

    phase = "R6";
    cps = 1; idle(5); cps = 0; idle(5);
    wr(1, 8'h02); idle(2);
    cps = 1; idle(4); cps = 0; idle(6);
    wr(1, 8'h02); idle(2);

    phase = "R7";
    state_tmo = 1; next(); state_tmo = 0; idle(3);
    wr(1, 8'h04); idle(2);

    phase = "R8";
    port_int_en = 4'b0101;
    port_stat[7:4] = 4'h9; idle(3);
    port_stat[11:8] = 4'h2; idle(3);
    wr(1, 8'h08); idle(2);
    port_stat[3:0] = 4'h8; idle(3);
    wr(1, 8'h08); idle(2);

    phase = "R9";
    wr(0, 8'h00);
    port_resume = 4'b0010; next(); port_resume = 0; idle(3);
    wr(0, 8'h08);
    port_resume = 4'b1000; next(); port_resume = 0; idle(3);
    wr(1, 8'h08); idle(2);

    phase = "R10";
    arb_tmo = 1; reg_en = 1; reg_we = 1; reg_addr = 1; reg_wdata = 8'h0F;
    next(); arb_tmo = 0; reg_we = 0; idle(3);
    state_tmo = 1; reg_we = 1; reg_addr = 1; reg_wdata = 8'h04;
    next(); state_tmo = 0; reg_we = 0; idle(3);

    phase = "R11";
    link_active = 1; idle(2);
    link_active = 0; idle(3);
    link_active = 1; idle(2);
    link_active = 0; idle(2);
    wr(1, 8'h01); idle(2);
    arb_tmo = 1; next(); arb_tmo = 0; idle(2);
    wr(0, 8'h00); idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule